// File: doc/BRIEF.md
# Power-Up Serial Configuration Loader

This block sets up a 16-bit configuration word once after reset and then holds it until the next reset. A two-bit source selector is sampled once, on the first clock after reset.

The selector picks one of three sources. In the first, the block acts as bus master to a three-wire serial EEPROM: it drives a divided serial clock, a chip-select and a command line, issues a read of word 0, and shifts in sixteen data bits, least significant first. In the second, an external controller supplies both a clock and the data, and the block captures the first sixteen bits it sees. In the third, three strap pins set three fixed bits over a parameterised default word.

The loader reports completion with a sticky done flag. It also drives a five-bit management address: this is zero for strap loading, and the low five bits of the loaded word in the two serial modes.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held and until loading completes, `cfg_done_o` is 0, `cfg_word_o` is 0, `mgmt_addr_o` is 0, and `ee_cs_o`, `ee_sclk_o` and `ee_di_o` are 0.
- R2: `mode_i` is sampled on the first clock edge after reset release. The encoding is 2'b10 for EEPROM master, 2'b01 for external controller, and 2'b00 or 2'b11 for strap defaults. Later changes of `mode_i` have no effect.
- R3: In EEPROM mode `ee_cs_o` rises on the second edge after reset release and stays high for exactly 26 serial periods. Each period lasts 2*HALF_DIV system clocks: `ee_sclk_o` is low for the first half and high for the second half. When `ee_cs_o` is low, `ee_sclk_o` is low.
- R4: `ee_di_o` changes only at the start of a period. Across the 26 periods it carries the start bit 1, the opcode bits 1 then 0, six address bits of 0, and then 0 for the rest.
- R5: `ee_do_i` is sampled as `ee_sclk_o` rises in periods 11 to 26. The sample from period 11 becomes bit 0 and the sample from period 26 becomes bit 15.
- R6: `ee_cs_o` falls one cycle after the end of period 26. On the cycle after that, `cfg_done_o` goes high and `cfg_word_o` shows the assembled word.
- R7: In controller mode the EEPROM outputs stay at 0. `ext_clk_i` and `ext_data_i` pass through two-flop synchronisers. On each of the first 16 rising edges of `ext_clk_i`, one data bit is captured, least significant first. `cfg_done_o` stays 0 after 15 edges and goes high after the 16th.
- R8: In controller mode, rising edges of `ext_clk_i` after the 16th leave `cfg_word_o` unchanged.
- R9: In strap mode `cfg_done_o` is high two cycles after reset release. The word equals DFLT_CFG (default 16'h1000) with bit 9 set from `strap_a_i`, bit 8 from `strap_b_i` and bit 10 from `strap_c_i`.
- R10: Once loading is done, `mgmt_addr_o` is 5'b00000 in strap mode and `cfg_word_o[4:0]` in the two serial modes.
- R11: Once `cfg_done_o` is high, it and `cfg_word_o` hold their values until reset, whatever the straps, clocks or data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Source selector |
| strap_a_i | input | 1 | Strap for word bit 9 |
| strap_b_i | input | 1 | Strap for word bit 8 |
| strap_c_i | input | 1 | Strap for word bit 10 |
| ext_clk_i | input | 1 | Controller-supplied shift clock |
| ext_data_i | input | 1 | Controller-supplied data |
| ee_do_i | input | 1 | Data returned by the EEPROM |
| ee_sclk_o | output | 1 | Serial clock to the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip-select |
| ee_di_o | output | 1 | Command/address line to the EEPROM |
| cfg_word_o | output | 16 | Loaded configuration word |
| cfg_done_o | output | 1 | Word valid, sticky |
| mgmt_addr_o | output | 5 | Management address |

## Verification
A wrong period counter or phase bit shows up on `ee_sclk_o`, `ee_cs_o` or `ee_di_o` in the very cycle it goes wrong. The bench's reference timeline compares all three on every clock, so such a fault is caught at once. A bit-index error in the shift path cannot be seen until the word is presented, one cycle after chip-select falls; it then appears as bits moved or reversed, and the test patterns 16'h0001 and 16'h8000 single out the two end positions. A broken freeze, or an edge counter that lets extra edges through, shows as a changed word after the extra controller edges or the strap changes that the bench applies once done has been seen.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    SRC_STRAP = 2'b00,
    SRC_CTRL  = 2'b01,
    SRC_EE    = 2'b10,
    SRC_RSVD  = 2'b11
  } src_mode_e;

  // command periods: start, 2 opcode, 6 address, 1 dummy before data
  localparam int unsigned EE_CMD_PERIODS = 10;
  localparam int unsigned EE_HI_CMD      = 2;  // periods carrying a 1
endpackage

// File: rtl/cfg_ee_master.sv
module cfg_ee_master
  import cfg_loader_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned CFG_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ee_do_i,
  output logic             sclk_o,
  output logic             cs_o,
  output logic             di_o,
  output logic [CFG_W-1:0] word_o,
  output logic             done_o
);
  localparam int unsigned TOTAL = EE_CMD_PERIODS + CFG_W;
  localparam int unsigned IDX_W = $clog2(TOTAL);
  localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);
  localparam int unsigned BIT_W = $clog2(CFG_W);

  logic             busy_q, fin_q, phase_q, done_q;
  logic [DIV_W-1:0] half_q;
  logic [IDX_W-1:0] idx_q;
  logic [CFG_W-1:0] word_q;
  logic [IDX_W-1:0] rel;
  logic             half_end;

  assign half_end = (half_q == DIV_W'(HALF_DIV - 1));
  assign rel      = idx_q - IDX_W'(EE_CMD_PERIODS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      half_q  <= '0;
      idx_q   <= '0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i && !fin_q) begin
          busy_q  <= 1'b1;
          half_q  <= '0;
          phase_q <= 1'b0;
          idx_q   <= '0;
        end
      end else if (!half_end) begin
        half_q <= half_q + 1'b1;
      end else begin
        half_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
          // sample on the rising serial edge
          if (idx_q >= IDX_W'(EE_CMD_PERIODS))
            word_q[rel[BIT_W-1:0]] <= ee_do_i;
        end else begin
          phase_q <= 1'b0;
          if (idx_q == IDX_W'(TOTAL - 1)) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o = phase_q;
  assign cs_o   = busy_q;
  assign di_o   = busy_q && (idx_q < IDX_W'(EE_HI_CMD));
  assign word_o = word_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfg_ext_shift.sv
module cfg_ext_shift #(
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ext_clk_i,
  input  logic             ext_data_i,
  output logic [CFG_W-1:0] word_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = $clog2(CFG_W + 1);
  localparam int unsigned BIT_W = $clog2(CFG_W);

  logic [2:0]       clk_sq;
  logic [1:0]       dat_sq;
  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] word_q;
  logic             done_q;
  logic             rise;

  assign rise = clk_sq[1] && !clk_sq[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sq <= '0;
      dat_sq <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      clk_sq <= {clk_sq[1:0], ext_clk_i};
      dat_sq <= {dat_sq[0], ext_data_i};
      done_q <= 1'b0;
      if (en_i && rise && (cnt_q < CNT_W'(CFG_W))) begin
        word_q[cnt_q[BIT_W-1:0]] <= dat_sq[1];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(CFG_W - 1)) done_q <= 1'b1;
      end
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned     HALF_DIV = 2,
  parameter int unsigned     CFG_W    = 16,
  parameter int unsigned     ADDR_W   = 5,
  parameter logic [CFG_W-1:0] DFLT_CFG = 16'h1000,
  parameter int unsigned     BIT_A    = 9,
  parameter int unsigned     BIT_B    = 8,
  parameter int unsigned     BIT_C    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              strap_a_i,
  input  logic              strap_b_i,
  input  logic              strap_c_i,
  input  logic              ext_clk_i,
  input  logic              ext_data_i,
  input  logic              ee_do_i,
  output logic              ee_sclk_o,
  output logic              ee_cs_o,
  output logic              ee_di_o,
  output logic [CFG_W-1:0]  cfg_word_o,
  output logic              cfg_done_o,
  output logic [ADDR_W-1:0] mgmt_addr_o
);
  src_mode_e        mode_q;
  logic             mode_vld_q, done_q;
  logic [CFG_W-1:0] cfg_q, hw_word, ee_word, ext_word;
  logic             ee_done, ext_done, sel_ee, sel_ctrl, sel_hw;

  assign sel_ee   = mode_vld_q && (mode_q == SRC_EE);
  assign sel_ctrl = mode_vld_q && (mode_q == SRC_CTRL);
  assign sel_hw   = mode_vld_q && (mode_q == SRC_STRAP || mode_q == SRC_RSVD);

  cfg_ee_master #(.HALF_DIV(HALF_DIV), .CFG_W(CFG_W)) u_ee (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sel_ee),
    .ee_do_i(ee_do_i),
    .sclk_o (ee_sclk_o),
    .cs_o   (ee_cs_o),
    .di_o   (ee_di_o),
    .word_o (ee_word),
    .done_o (ee_done)
  );

  cfg_ext_shift #(.CFG_W(CFG_W)) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (sel_ctrl),
    .ext_clk_i (ext_clk_i),
    .ext_data_i(ext_data_i),
    .word_o    (ext_word),
    .done_o    (ext_done)
  );

  always_comb begin
    hw_word        = DFLT_CFG;
    hw_word[BIT_A] = strap_a_i;
    hw_word[BIT_B] = strap_b_i;
    hw_word[BIT_C] = strap_c_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= SRC_STRAP;
      mode_vld_q <= 1'b0;
      done_q     <= 1'b0;
      cfg_q      <= '0;
    end else if (!done_q) begin
      if (!mode_vld_q) begin
        mode_vld_q <= 1'b1;
        mode_q     <= src_mode_e'(mode_i);
      end else if (sel_hw) begin
        cfg_q  <= hw_word;
        done_q <= 1'b1;
      end else if (sel_ctrl && ext_done) begin
        cfg_q  <= ext_word;
        done_q <= 1'b1;
      end else if (sel_ee && ee_done) begin
        cfg_q  <= ee_word;
        done_q <= 1'b1;
      end
    end
  end

  assign cfg_word_o  = cfg_q;
  assign cfg_done_o  = done_q;
  assign mgmt_addr_o = (done_q && !sel_hw) ? cfg_q[ADDR_W-1:0] : '0;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int unsigned CFG_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ee_sclk_o,
  input logic              ee_cs_o,
  input logic              cfg_done_o,
  input logic [CFG_W-1:0]  cfg_word_o,
  input logic [ADDR_W-1:0] mgmt_addr_o,
  input logic              hw_sel
);
  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_cs_o |-> !ee_sclk_o);
  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> cfg_done_o);
  // R11
  word_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> $stable(cfg_word_o));
  // R6
  cs_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ee_cs_o) |=> cfg_done_o);
  // R1
  cs_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |-> !ee_cs_o);
  // R10
  hw_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_o && hw_sel) |-> (mgmt_addr_o == '0));
endmodule

bind cfg_loader cfg_loader_chk #(.CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ee_sclk_o  (ee_sclk_o),
  .ee_cs_o    (ee_cs_o),
  .cfg_done_o (cfg_done_o),
  .cfg_word_o (cfg_word_o),
  .mgmt_addr_o(mgmt_addr_o),
  .hw_sel     (sel_hw)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  localparam int H = 2;
  localparam logic [15:0] DFLT = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sa = 1'b0, sb = 1'b0, sc = 1'b0;
  logic        ext_clk = 1'b0, ext_data = 1'b0, ee_do = 1'b0;
  logic        sclk, cs, di, done;
  logic [15:0] word;
  logic [4:0]  addr;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cfg_loader #(.HALF_DIV(H)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .strap_a_i(sa), .strap_b_i(sb), .strap_c_i(sc),
    .ext_clk_i(ext_clk), .ext_data_i(ext_data), .ee_do_i(ee_do),
    .ee_sclk_o(sclk), .ee_cs_o(cs), .ee_di_o(di),
    .cfg_word_o(word), .cfg_done_o(done), .mgmt_addr_o(addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_ni = 1'b0;
    mode = m;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({done, word, addr, cs, sclk, di} == '0, "R1 reset state",
        {8'h0, done, cs, sclk, di, word}, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic run_ee(input logic [15:0] w, input bit flip);
    int n_rise = 0;
    bit prev = 1'b0;
    ext_clk = 0; ext_data = 0; ee_do = 0;
    do_reset(2'b10);
    for (int k = 1; k <= 52*H + 4; k++) begin
      int s;
      bit e_cs, e_sclk, e_di, e_done;
      @(negedge clk);
      if (flip && k == 5) mode = 2'b01;  // R2: ignored after capture
      s = k - 2;
      e_cs = (s >= 0) && (s < 52*H);
      e_sclk = e_cs && ((s % (2*H)) >= H);
      e_di = e_cs && ((s / (2*H)) < 2);
      e_done = (s >= 52*H + 1);
      chk({cs, sclk} == {e_cs, e_sclk}, "R3 cs/sclk timeline", {cs, sclk}, {e_cs, e_sclk});
      chk(di == e_di, "R4 command line", di, e_di);
      chk(done == e_done, "R6 done timing", done, e_done);
      if (sclk && !prev) n_rise++;
      prev = sclk;
      ee_do = (n_rise >= 10 && n_rise <= 25) ? w[n_rise-10] : 1'b0;
    end
    chk(word == w, "R5 LSB-first word", word, w);
    chk(addr == w[4:0], "R10 serial addr", addr, w[4:0]);
    repeat (5) @(negedge clk);
    chk(word == w && done, "R11 frozen after ee", word, w);
  endtask

  task automatic ext_edge(input logic b);
    ext_data = b;
    repeat (3) @(negedge clk);
    ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_ctrl(input logic [15:0] w);
    ee_do = 1'b1;
    do_reset(2'b01);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      ext_edge(w[i]);
      chk({cs, sclk, di} == 3'b000, "R7 ee lines idle", {cs, sclk, di}, 0);
      if (i == 14) chk(done == 1'b0, "R7 not done after 15 edges", done, 0);
    end
    repeat (2) @(negedge clk);
    chk(done == 1'b1, "R7 done after 16 edges", done, 1);
    chk(word == w, "R7 captured word", word, w);
    chk(addr == w[4:0], "R10 ctrl addr", addr, w[4:0]);
    for (int i = 0; i < 3; i++) ext_edge(~w[i]);
    chk(word == w, "R8 extra edges ignored", word, w);
  endtask

  task automatic run_hw(input logic [1:0] m, input logic a, input logic b, input logic c);
    logic [15:0] e;
    e = DFLT;
    e[9] = a; e[8] = b; e[10] = c;
    sa = a; sb = b; sc = c;
    do_reset(m);
    @(negedge clk);
    chk(done == 1'b0, "R9 not done after 1 cycle", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R9 done after 2 cycles", done, 1);
    chk(word == e, "R9 strap word", word, e);
    chk(addr == 5'd0, "R10 strap addr", addr, 0);
    sa = ~a; sb = ~b; sc = ~c; mode = 2'b10;
    repeat (6) @(negedge clk);
    chk(word == e && done, "R11 straps frozen", word, e);
    chk(cs == 1'b0, "R2 late mode change ignored", cs, 0);
  endtask

  initial begin
    run_ee(16'hA5C3, 1'b1);
    run_ee(16'h0001, 1'b0);
    run_ee(16'h8000, 1'b0);
    run_ctrl(16'h3C5A);
    run_ctrl(16'h8001);
    run_hw(2'b00, 1'b1, 1'b0, 1'b1);
    run_hw(2'b11, 1'b0, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule